// File: doc/BRIEF.md
# Reset Sequencer with Source Discrimination

This block sequences reset for a small microcontroller core. After the power-up event it keeps the core in reset until a stabilization count of clock cycles has passed with the oscillator running. If the external reset line is still low at that point, it keeps the core in reset until the line goes high.

The reset line is shared and open-drain. When the watchdog or the clock monitor requests a reset, the block pulls the line low for a fixed number of bus-clock (E) enables and then releases it. After a fixed gap, also counted in bus-clock enables, it reads the line once. A low reading means an outside agent is also holding reset, so the cause is recorded as external and the core stays in reset until the line rises. A high reading records the internal source. The cause code is readable at all times and changes only when a new reset event is classified.

The pin level passes through a synchronizer before the state machine uses it. The watchdog counter and supply monitoring are outside this block.

Top module: `reset_sequencer`

## Requirements
- R1: While `porPulse` is high, `coreReset`=1, `pinPullLow`=0 and `causeCode`=2'b00 (power-on). After `porPulse` falls, `coreReset` deasserts once `oscActive` has been high on STAB_CYCLES clock edges. Edges on which `oscActive` is low are not counted.
- R2: If the synchronized pin is low when the stabilization count completes, `coreReset` stays 1 and `causeCode` stays 2'b00 until the synchronized pin reads high.
- R3: A watchdog or clock-monitor request in the running state raises `pinPullLow`. It stays high for exactly DRIVE_CYCLES clock edges on which `busEn`=1, and edges without `busEn` do not advance the count.
- R4: After the release, the synchronized pin is sampled once, on the clock edge that follows the GAP_CYCLES-th edge with `busEn`=1. `coreReset` stays 1 through that sample and falls only after it, and only if the pin reads high.
- R5: If the sample is high, `causeCode` becomes 2'b10 for a watchdog request or 2'b11 for a clock-monitor request. When both requests arrive on the same edge, the result is 2'b11.
- R6: If the sample is low, `causeCode` becomes 2'b01 (external) and `coreReset` stays 1 until the synchronized pin reads high.
- R7: In the running state, a low synchronized pin with no internal request asserts `coreReset` and sets `causeCode` to 2'b01. `pinPullLow` stays 0, and reset holds until the pin reads high.
- R8: The pin goes through a two-flop synchronizer. A change of `pinIn` set up before a clock edge first affects the state machine on the third edge.
- R9: Watchdog and clock-monitor requests are ignored outside the running state, and `causeCode` does not change between classifications.
- R10: Only `porPulse` starts the power-on delay. Dropping `oscActive` while running has no effect on `coreReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| porPulse | input | 1 | Power-up event, active high, synchronous |
| oscActive | input | 1 | Oscillator running flag |
| wdogReq | input | 1 | Watchdog timeout request |
| clkMonReq | input | 1 | Clock-monitor failure request |
| busEn | input | 1 | Bus (E) clock enable, one clock wide |
| pinIn | input | 1 | Raw level of the shared reset pin |
| pinPullLow | output | 1 | Open-drain pull-down enable for the reset pin |
| coreReset | output | 1 | Reset to the core, active high |
| causeCode | output | 2 | Last reset cause: 00 power-on, 01 external, 10 watchdog, 11 clock monitor |

## Verification
The bench builds the block with STAB_CYCLES=12, DRIVE_CYCLES=4, GAP_CYCLES=2 and SYNC_STAGES=2. The short stabilization count means the power-on path, including the case where the pin is still held low at the end of the count, can be repeated several times in one run. With the drive and gap windows this small, the bench can run the full drive-release-sample sequence under three bus-enable patterns: every third clock, every clock, and stalled. It also covers the external-hold and request-priority cases.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_POR_WAIT,
    ST_DRIVE_LOW,
    ST_RELEASE_WAIT,
    ST_SAMPLE,
    ST_HOLD_EXT,
    ST_RUN
  } seqState_e;

  typedef enum logic [1:0] {
    CAUSE_POWER    = 2'b00,
    CAUSE_EXTERNAL = 2'b01,
    CAUSE_WATCHDOG = 2'b10,
    CAUSE_CLKMON   = 2'b11
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic stabInc;
    logic busInc;
    logic busClr;
    logic capPend;
    logic loadExt;
    logic loadPend;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic stabLast;
    logic driveLast;
    logic gapLast;
    logic pinHigh;
  } dpStatus_t;

endpackage

// File: rtl/rstseq_dpath.sv
module rstseq_dpath
  import rstseq_pkg::*;
#(
  parameter int STAB_CYCLES = 4064,
  parameter int DRIVE_CYCLES = 4,
  parameter int GAP_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porPulse,
  input  logic       pinIn,
  input  logic       clkMonReq,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status,
  output cause_e     causeCode
);

  localparam int STAB_W  = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam int BUS_MAX = (DRIVE_CYCLES > GAP_CYCLES) ? DRIVE_CYCLES : GAP_CYCLES;
  localparam int BUS_W   = $clog2(BUS_MAX + 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [STAB_W-1:0]      stabCnt;
  logic [BUS_W-1:0]       busCnt;
  cause_e                 pendCause;
  cause_e                 causeReg;

  // pin synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (porPulse) syncChain <= '0;
        else          syncChain <= pinIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (porPulse) syncChain <= '0;
        else          syncChain <= {syncChain[SYNC_STAGES-2:0], pinIn};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (porPulse) begin
      stabCnt <= '0;
    end else if (strobe.stabInc && !status.stabLast) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (porPulse || strobe.busClr) begin
      busCnt <= '0;
    end else if (strobe.busInc) begin
      busCnt <= busCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (porPulse) begin
      pendCause <= CAUSE_WATCHDOG;
    end else if (strobe.capPend) begin
      pendCause <= clkMonReq ? CAUSE_CLKMON : CAUSE_WATCHDOG;
    end
  end

  always_ff @(posedge clk) begin
    if (porPulse) begin
      causeReg <= CAUSE_POWER;
    end else if (strobe.loadExt) begin
      causeReg <= CAUSE_EXTERNAL;
    end else if (strobe.loadPend) begin
      causeReg <= pendCause;
    end
  end

  always_comb begin
    status.stabLast  = (stabCnt == STAB_W'(STAB_CYCLES - 1));
    status.driveLast = (busCnt == BUS_W'(DRIVE_CYCLES - 1));
    status.gapLast   = (busCnt == BUS_W'(GAP_CYCLES - 1));
    status.pinHigh   = syncChain[SYNC_STAGES-1];
  end

  assign causeCode = causeReg;

  // R1: stabilization counter never passes its final value
  a_r1_stab_in_range: assert property (@(posedge clk) disable iff (porPulse)
    stabCnt <= STAB_W'(STAB_CYCLES - 1));

  // R3: bus-cycle counter stays inside the longest window
  a_r3_bus_in_range: assert property (@(posedge clk) disable iff (porPulse)
    busCnt < BUS_W'(BUS_MAX));

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       porPulse,
  input  logic       oscActive,
  input  logic       wdogReq,
  input  logic       clkMonReq,
  input  logic       busEn,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       pinPullLow,
  output logic       coreReset
);

  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (porPulse) state <= ST_POR_WAIT;
    else          state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_POR_WAIT: begin
        if (oscActive) begin
          strobe.stabInc = 1'b1;
          if (status.stabLast) nextState = status.pinHigh ? ST_RUN : ST_HOLD_EXT;
        end
      end
      ST_RUN: begin
        strobe.busClr = 1'b1;
        if (wdogReq || clkMonReq) begin
          strobe.capPend = 1'b1;
          nextState      = ST_DRIVE_LOW;
        end else if (!status.pinHigh) begin
          strobe.loadExt = 1'b1;
          nextState      = ST_HOLD_EXT;
        end
      end
      ST_DRIVE_LOW: begin
        if (busEn) begin
          if (status.driveLast) begin
            strobe.busClr = 1'b1;
            nextState     = ST_RELEASE_WAIT;
          end else begin
            strobe.busInc = 1'b1;
          end
        end
      end
      ST_RELEASE_WAIT: begin
        if (busEn) begin
          if (status.gapLast) begin
            strobe.busClr = 1'b1;
            nextState     = ST_SAMPLE;
          end else begin
            strobe.busInc = 1'b1;
          end
        end
      end
      ST_SAMPLE: begin
        if (status.pinHigh) begin
          strobe.loadPend = 1'b1;
          nextState       = ST_RUN;
        end else begin
          strobe.loadExt = 1'b1;
          nextState      = ST_HOLD_EXT;
        end
      end
      ST_HOLD_EXT: begin
        if (status.pinHigh) nextState = ST_RUN;
      end
      default: nextState = ST_POR_WAIT;
    endcase
  end

  assign coreReset  = (state != ST_RUN);
  assign pinPullLow = (state == ST_DRIVE_LOW);

  // R4: core leaves reset only when the synchronized pin was high
  a_r4_release_needs_pin_high: assert property (@(posedge clk) disable iff (porPulse)
    $fell(coreReset) |-> $past(status.pinHigh));

  // R3: the pin is only pulled after a request seen while running
  a_r3_pull_starts_from_run: assert property (@(posedge clk) disable iff (porPulse)
    $rose(pinPullLow) |-> $past(state) == ST_RUN);

  // R6: external hold keeps the core in reset while the pin is low
  a_r6_hold_while_low: assert property (@(posedge clk) disable iff (porPulse)
    (state == ST_HOLD_EXT && !status.pinHigh) |=> coreReset);

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int STAB_CYCLES = 4064,
  parameter int DRIVE_CYCLES = 4,
  parameter int GAP_CYCLES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porPulse,
  input  logic       oscActive,
  input  logic       wdogReq,
  input  logic       clkMonReq,
  input  logic       busEn,
  input  logic       pinIn,
  output logic       pinPullLow,
  output logic       coreReset,
  output logic [1:0] causeCode
);

  ctlStrobe_t strobe;
  dpStatus_t  status;
  cause_e     causeVal;

  rstseq_ctrl u_ctrl (
    .clk        (clk),
    .porPulse   (porPulse),
    .oscActive  (oscActive),
    .wdogReq    (wdogReq),
    .clkMonReq  (clkMonReq),
    .busEn      (busEn),
    .status     (status),
    .strobe     (strobe),
    .pinPullLow (pinPullLow),
    .coreReset  (coreReset)
  );

  rstseq_dpath #(
    .STAB_CYCLES  (STAB_CYCLES),
    .DRIVE_CYCLES (DRIVE_CYCLES),
    .GAP_CYCLES   (GAP_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dpath (
    .clk       (clk),
    .porPulse  (porPulse),
    .pinIn     (pinIn),
    .clkMonReq (clkMonReq),
    .strobe    (strobe),
    .status    (status),
    .causeCode (causeVal)
  );

  assign causeCode = causeVal;

  // R9: the cause code is frozen while the pin is being pulled
  a_r9_cause_frozen_in_drive: assert property (@(posedge clk) disable iff (porPulse)
    pinPullLow |=> $stable(causeCode));

endmodule

// File: tb/test_reset_sequencer.sv
module test_reset_sequencer;

  localparam int STAB  = 12;
  localparam int DRIVE = 4;
  localparam int GAP   = 2;

  logic clk = 1'b0;
  logic porPulse = 1'b1, oscActive = 1'b0, wdogReq = 1'b0, clkMonReq = 1'b0;
  logic busEn = 1'b0, pinIn = 1'b1;
  logic pinPullLow, coreReset;
  logic [1:0] causeCode;

  int checks = 0, fails = 0;
  int busMode = 0;
  bit started = 0;

  always #10 clk = ~clk;

  reset_sequencer #(.STAB_CYCLES(STAB), .DRIVE_CYCLES(DRIVE), .GAP_CYCLES(GAP), .SYNC_STAGES(2))
    i_reset_sequencer (
      .clk(clk), .porPulse(porPulse), .oscActive(oscActive), .wdogReq(wdogReq),
      .clkMonReq(clkMonReq), .busEn(busEn), .pinIn(pinIn),
      .pinPullLow(pinPullLow), .coreReset(coreReset), .causeCode(causeCode));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // behavioural reference: phase 0 power wait, 1 pulling, 2 gap, 3 sample, 4 held, 5 running
  int mPhase = 0, mCnt = 0, mCause = 0, mPend = 2;
  bit pinHist[$] = '{1'b0, 1'b0};

  always @(posedge clk) begin
    bit syncV;
    started = 1;
    if (porPulse) begin
      mPhase = 0; mCnt = 0; mCause = 0; mPend = 2;
      pinHist = '{1'b0, 1'b0};
    end else begin
      syncV = pinHist[0];
      case (mPhase)
        0: if (oscActive) begin
             if (mCnt == STAB - 1) mPhase = syncV ? 5 : 4;
             else mCnt++;
           end
        5: if (wdogReq || clkMonReq) begin
             mPend = clkMonReq ? 3 : 2; mPhase = 1; mCnt = 0;
           end else if (!syncV) begin
             mCause = 1; mPhase = 4;
           end
        1: if (busEn) begin
             if (mCnt == DRIVE - 1) begin mPhase = 2; mCnt = 0; end else mCnt++;
           end
        2: if (busEn) begin
             if (mCnt == GAP - 1) begin mPhase = 3; mCnt = 0; end else mCnt++;
           end
        3: if (syncV) begin mCause = mPend; mPhase = 5; end
           else begin mCause = 1; mPhase = 4; end
        default: if (syncV) mPhase = 5;
      endcase
      pinHist.push_back(pinIn);
      void'(pinHist.pop_front());
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (started) begin
      chk(pinPullLow === (mPhase == 1), "R3 model pinPullLow", int'(pinPullLow), int'(mPhase == 1));
      chk(coreReset === (mPhase != 5), "R4 model coreReset", int'(coreReset), int'(mPhase != 5));
      chk(causeCode === 2'(mCause), "R5 model causeCode", int'(causeCode), mCause);
    end
  end

  // bus enable pattern generator
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 3;
      case (busMode)
        0: busEn = (div == 0);
        1: busEn = 1'b1;
        default: busEn = 1'b0;
      endcase
    end
  end

  initial begin
    #(20ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitRun(input int maxC);
    for (int i = 0; i < maxC; i++) begin
      if (!coreReset) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic pulseReq(input bit wd, input bit cm);
    @(negedge clk);
    wdogReq = wd; clkMonReq = cm;
    @(negedge clk);
    wdogReq = 0; clkMonReq = 0;
    #1;
  endtask

  task automatic countDrive(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      if (!pinPullLow) break;
      if (busEn) n++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    int n;
    // power-on
    cyc(3); #1;
    chk(coreReset === 1'b1, "R1 reset coreReset", int'(coreReset), 1);
    chk(pinPullLow === 1'b0, "R1 reset pinPullLow", int'(pinPullLow), 0);
    chk(causeCode === 2'b00, "R1 reset causeCode", int'(causeCode), 0);
    @(negedge clk); porPulse = 0;
    cyc(6); #1;
    chk(coreReset === 1'b1, "R1 held while oscillator off", int'(coreReset), 1);
    @(negedge clk); oscActive = 1;
    cyc(STAB - 1); #1;
    chk(coreReset === 1'b1, "R1 still held one edge early", int'(coreReset), 1);
    cyc(1); #1;
    chk(coreReset === 1'b0, "R1 released after count", int'(coreReset), 0);

    // R10: oscillator drop while running
    @(negedge clk); oscActive = 0;
    cyc(10); #1;
    chk(coreReset === 1'b0, "R10 osc drop ignored", int'(coreReset), 0);
    @(negedge clk); oscActive = 1;

    // R3/R5 watchdog, pin released by all
    pulseReq(1, 0);
    chk(pinPullLow === 1'b1, "R3 pull starts", int'(pinPullLow), 1);
    countDrive(n);
    chk(n == DRIVE, "R3 drive length", n, DRIVE);
    waitRun(50);
    chk(coreReset === 1'b0, "R4 released after high sample", int'(coreReset), 0);
    chk(causeCode === 2'b10, "R5 watchdog cause", int'(causeCode), 2);

    // R5 both requests together
    pulseReq(1, 1);
    waitRun(50);
    chk(causeCode === 2'b11, "R5 clock monitor wins", int'(causeCode), 3);

    // R6 external agent also holding
    @(negedge clk); wdogReq = 1; pinIn = 0;
    @(negedge clk); wdogReq = 0;
    cyc(40); #1;
    chk(coreReset === 1'b1, "R6 held by external", int'(coreReset), 1);
    chk(causeCode === 2'b01, "R6 external cause", int'(causeCode), 1);
    @(negedge clk); pinIn = 1;
    cyc(2); #1;
    chk(coreReset === 1'b1, "R8 two edges of latency", int'(coreReset), 1);
    cyc(1); #1;
    chk(coreReset === 1'b0, "R8 released on third edge", int'(coreReset), 0);

    // R7 external pin drop while running, R9 requests ignored while held
    @(negedge clk); pinIn = 0;
    cyc(2); #1;
    chk(coreReset === 1'b0, "R7 not yet seen", int'(coreReset), 0);
    cyc(1); #1;
    chk(coreReset === 1'b1, "R7 external reset", int'(coreReset), 1);
    chk(pinPullLow === 1'b0, "R7 no pull", int'(pinPullLow), 0);
    chk(causeCode === 2'b01, "R7 external cause", int'(causeCode), 1);
    pulseReq(0, 1);
    cyc(3); #1;
    chk(pinPullLow === 1'b0, "R9 request ignored in hold", int'(pinPullLow), 0);
    chk(causeCode === 2'b01, "R9 cause unchanged", int'(causeCode), 1);
    @(negedge clk); pinIn = 1;
    waitRun(20);
    chk(coreReset === 1'b0, "R7 released when pin high", int'(coreReset), 0);

    // R9 request during drive ignored
    @(negedge clk); wdogReq = 1;
    @(negedge clk); wdogReq = 0; clkMonReq = 1;
    @(negedge clk); clkMonReq = 0;
    waitRun(60);
    chk(causeCode === 2'b10, "R9 late clock monitor ignored", int'(causeCode), 2);

    // R3 bus enable gating
    busMode = 2;
    pulseReq(1, 0);
    cyc(20); #1;
    chk(pinPullLow === 1'b1, "R3 stalled without bus enable", int'(pinPullLow), 1);
    busMode = 1;
    @(negedge clk); #1;
    countDrive(n);
    chk(n == DRIVE, "R3 drive length fast enable", n, DRIVE);
    waitRun(20);
    chk(causeCode === 2'b10, "R5 watchdog fast enable", int'(causeCode), 2);
    busMode = 0;

    // R2 power-on with pin held low
    @(negedge clk); porPulse = 1; pinIn = 0;
    cyc(3);
    @(negedge clk); porPulse = 0;
    cyc(STAB + 10); #1;
    chk(coreReset === 1'b1, "R2 held past count", int'(coreReset), 1);
    chk(causeCode === 2'b00, "R2 cause stays power-on", int'(causeCode), 0);
    @(negedge clk); pinIn = 1;
    cyc(2); #1;
    chk(coreReset === 1'b1, "R8 latency after power-on", int'(coreReset), 1);
    cyc(1); #1;
    chk(coreReset === 1'b0, "R2 released when pin high", int'(coreReset), 0);
    chk(causeCode === 2'b00, "R2 cause after release", int'(causeCode), 0);

    cyc(5);
    summary();
  end

endmodule